// File: doc/BRIEF.md
# Three-Wire Display Controller Serial Interface

This block is the host-facing slave port of a segment display controller. A host drives four lines: an active-low select, a write clock, a read clock and one bidirectional data line. All four are brought into a fast system clock domain through two-stage synchronisers, and their edges are found there. Every transfer opens with a three-bit mode code after select falls. The code selects one of three transfers: reading nibbles out of a 64 x 4-bit display memory, writing nibbles into it (optionally reading each nibble back before it is overwritten), or sending a chain of nine-bit commands.

In the data modes, the code is followed by a six-bit address and then any number of four-bit nibbles. The address steps up by one after each nibble and wraps from 63 back to 0. In command mode, each completed nine-bit word produces a one-cycle strobe with the captured code. It also produces a decoded strobe for the system, display and interrupt controls, and for the bias/commons and time-base settings, which come with their payload fields. Raising select abandons whatever is in flight. The block drives a data-line output enable, which is active only while it is returning read data.

Top module: `lcd3w_serial_if`

## Requirements
- R1: After reset the memory holds zero everywhere, the output enable is low and no strobe is active.
- R2: After mode code 101 (sent 1, 0, 1), six address bits are taken most significant first on write-clock rising edges, then four data bits least significant first; the nibble is stored at that address.
- R3: After mode code 110 and an address, each read-clock falling edge places the next stored bit on `dat_o`, least significant first, with `dat_oe_o` high; the host samples it at the following rising edge.
- R4: In both read and write bursts, each completed nibble advances the address by one, wrapping from 63 to 0.
- R5: In mode 101, read-clock falling edges before a nibble's write bits return the nibble stored at the current address. The write bits that follow replace that nibble, and only then does the address advance.
- R6: After mode code 100, each group of nine write-clock bits (most significant first) forms one command, signalled by a one-cycle `cmd_stb_o` with the code on `cmd_code_o`; further commands follow without a new mode code.
- R7: With code bits c[8:1]: 00000000 pulses `sys_dis_o`, 00000001 `sys_en_o`, 00000010 `lcd_off_o`, 00000011 `lcd_on_o`; c[8:6]=100 pulses `irq_dis_o` when c[4]=0 and `irq_en_o` when c[4]=1 (c[5] ignored). At most one of these strobes is high in a cycle.
- R8: c[8:5]=0010 pulses `bias_wr_o` with `com_sel_o`=c[4:3] and `bias_third_o`=c[1]; c[8:6]=101 with c[4]=0 pulses `tbase_wr_o` with `tbase_sel_o`=c[3:1].
- R9: Select high abandons the transfer: a partly received nibble or command has no effect. After select falls again, the first three bits are always taken as a mode code.
- R10: A mode code other than 110, 101 or 100 makes the rest of the transfer inert: no memory change, no strobe, output enable low.
- R11: `dat_oe_o` is high only in a read phase and falls in the same instant that `cs_n_i` rises, without waiting for the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Active-low reset |
| cs_n_i | input | 1 | Select, active low; high resets the interface |
| wr_clk_i | input | 1 | Write clock; bits captured on rising edge |
| rd_clk_i | input | 1 | Read clock; bits launched on falling edge |
| dat_i | input | 1 | Data line as seen at the pad input |
| dat_o | output | 1 | Data line value driven during reads |
| dat_oe_o | output | 1 | Data line output enable |
| cmd_stb_o | output | 1 | One-cycle pulse per completed command |
| cmd_code_o | output | 9 | Last completed command code |
| sys_dis_o | output | 1 | System disable strobe |
| sys_en_o | output | 1 | System enable strobe |
| lcd_off_o | output | 1 | Display drive off strobe |
| lcd_on_o | output | 1 | Display drive on strobe |
| bias_wr_o | output | 1 | Bias/commons setting strobe |
| com_sel_o | output | 2 | Commons select payload |
| bias_third_o | output | 1 | One-third bias payload |
| irq_dis_o | output | 1 | Interrupt output disable strobe |
| irq_en_o | output | 1 | Interrupt output enable strobe |
| tbase_wr_o | output | 1 | Time-base frequency setting strobe |
| tbase_sel_o | output | 3 | Time-base frequency payload |

## Verification
The hardest case to reach is read-modify-write across a nibble boundary. There, read-clock pulses and write-clock pulses alternate within one select window, and the output enable has to rise and fall around each write nibble while the address steps only after the write. The bench first fills two neighbouring addresses with known, distinct nibbles. It then opens one 101 transfer that reads, writes, reads and writes again, and reads both addresses back in a fresh transfer. Aborts are reached by raising select mid-nibble and by sending a bare command with no mode code.

// File: rtl/lcd3w_serial_if.sv
module lcd3w_serial_if #(
  parameter int AW = 6,
  parameter int DW = 4,
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n_i,
  input  logic          wr_clk_i,
  input  logic          rd_clk_i,
  input  logic          dat_i,
  output logic          dat_o,
  output logic          dat_oe_o,
  output logic          cmd_stb_o,
  output logic [CW-1:0] cmd_code_o,
  output logic          sys_dis_o,
  output logic          sys_en_o,
  output logic          lcd_off_o,
  output logic          lcd_on_o,
  output logic          bias_wr_o,
  output logic [1:0]    com_sel_o,
  output logic          bias_third_o,
  output logic          irq_dis_o,
  output logic          irq_en_o,
  output logic          tbase_wr_o,
  output logic [2:0]    tbase_sel_o
);
  localparam int DEPTH = 1 << AW;
  localparam int CBW   = $clog2(CW + 1);
  localparam int NBW   = $clog2(DW);
  localparam int RBW   = NBW + 1;

  typedef enum logic [2:0] {S_IDLE, S_ID, S_ADDR, S_RD, S_WDAT, S_CMD, S_DEAD} st_t;

  logic [2:0] cs_q, wr_q, rd_q, d_q;
  logic cs_s, din, wr_rise, rd_fall;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_q <= '1; wr_q <= '1; rd_q <= '1; d_q <= '0;
    end else begin
      cs_q <= {cs_q[1:0], cs_n_i};
      wr_q <= {wr_q[1:0], wr_clk_i};
      rd_q <= {rd_q[1:0], rd_clk_i};
      d_q  <= {d_q[1:0], dat_i};
    end

  assign cs_s    = cs_q[1];
  assign din     = d_q[1];
  assign wr_rise = wr_q[1] & ~wr_q[2];
  assign rd_fall = ~rd_q[1] & rd_q[2];

  st_t            st;
  logic           rdmode, oe_q, dout_q, stb_q;
  logic [CBW-1:0] bcnt;
  logic [RBW-1:0] rbit;
  logic [AW-1:0]  addr;
  logic [CW-1:0]  sh, cmd_q;
  logic [DW-1:0]  wnib, wnib_nx;
  logic [DW-1:0]  mem [DEPTH];
  logic [2:0]     id_nx;

  assign id_nx = {sh[1:0], din};

  always_comb begin
    wnib_nx = wnib;
    wnib_nx[bcnt[NBW-1:0]] = din;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; rdmode <= 1'b0; oe_q <= 1'b0; dout_q <= 1'b0; stb_q <= 1'b0;
      bcnt <= '0; rbit <= '0; addr <= '0; sh <= '0; cmd_q <= '0; wnib <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      stb_q <= 1'b0;
      if (cs_s) begin
        st <= S_IDLE; oe_q <= 1'b0; bcnt <= '0; rbit <= '0;
      end else begin
        case (st)
          S_IDLE: begin st <= S_ID; bcnt <= '0; end
          S_ID: if (wr_rise) begin
            sh   <= {sh[CW-2:0], din};
            bcnt <= bcnt + 1'b1;
            if (bcnt == CBW'(2)) begin
              bcnt <= '0;
              case (id_nx)
                3'b110:  begin st <= S_ADDR; rdmode <= 1'b1; end
                3'b101:  begin st <= S_ADDR; rdmode <= 1'b0; end
                3'b100:  st <= S_CMD;
                default: st <= S_DEAD;
              endcase
            end
          end
          S_ADDR: if (wr_rise) begin
            addr <= {addr[AW-2:0], din};
            bcnt <= bcnt + 1'b1;
            if (bcnt == CBW'(AW - 1)) begin
              bcnt <= '0; rbit <= '0;
              st   <= rdmode ? S_RD : S_WDAT;
              oe_q <= rdmode;
            end
          end
          S_RD: if (rd_fall) begin
            dout_q <= mem[addr][rbit[NBW-1:0]];
            if (rbit == RBW'(DW - 1)) begin
              rbit <= '0; addr <= addr + 1'b1;
            end else rbit <= rbit + 1'b1;
          end
          S_WDAT: begin
            if (rd_fall && rbit < RBW'(DW)) begin
              dout_q <= mem[addr][rbit[NBW-1:0]];
              rbit   <= rbit + 1'b1;
              oe_q   <= 1'b1;
            end
            if (wr_rise) begin
              oe_q <= 1'b0;
              wnib <= wnib_nx;
              if (bcnt == CBW'(DW - 1)) begin
                mem[addr] <= wnib_nx;
                addr <= addr + 1'b1;
                bcnt <= '0; rbit <= '0;
              end else bcnt <= bcnt + 1'b1;
            end
          end
          S_CMD: if (wr_rise) begin
            sh <= {sh[CW-2:0], din};
            if (bcnt == CBW'(CW - 1)) begin
              cmd_q <= {sh[CW-2:0], din};
              stb_q <= 1'b1;
              bcnt  <= '0;
            end else bcnt <= bcnt + 1'b1;
          end
          default: ;
        endcase
      end
    end

  assign dat_o        = dout_q;
  assign dat_oe_o     = oe_q & ~cs_n_i;
  assign cmd_stb_o    = stb_q;
  assign cmd_code_o   = cmd_q;
  assign sys_dis_o    = stb_q && cmd_q[8:1] == 8'b0000_0000;
  assign sys_en_o     = stb_q && cmd_q[8:1] == 8'b0000_0001;
  assign lcd_off_o    = stb_q && cmd_q[8:1] == 8'b0000_0010;
  assign lcd_on_o     = stb_q && cmd_q[8:1] == 8'b0000_0011;
  assign bias_wr_o    = stb_q && cmd_q[8:5] == 4'b0010;
  assign irq_dis_o    = stb_q && cmd_q[8:6] == 3'b100 && !cmd_q[4];
  assign irq_en_o     = stb_q && cmd_q[8:6] == 3'b100 && cmd_q[4];
  assign tbase_wr_o   = stb_q && cmd_q[8:6] == 3'b101 && !cmd_q[4];
  assign com_sel_o    = cmd_q[4:3];
  assign bias_third_o = cmd_q[1];
  assign tbase_sel_o  = cmd_q[3:1];

  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (st == S_IDLE && !oe_q && bcnt == '0));

  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_s && st == S_RD && rd_fall && rbit == RBW'(DW - 1)) |=> addr == $past(addr) + 1'b1);

  p_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_s && st == S_WDAT && wr_rise && bcnt == CBW'(DW - 1)) |=> mem[$past(addr)] == $past(wnib_nx));

  p_stb_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb_o |=> !cmd_stb_o);

  p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sys_dis_o, sys_en_o, lcd_off_o, lcd_on_o, bias_wr_o, irq_dis_o, irq_en_o, tbase_wr_o}));

  p_dead_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_DEAD |-> (!oe_q && !stb_q));

  p_oe_phase_r11: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> (st == S_RD || st == S_WDAT));
endmodule

// File: tb/tb_lcd3w_serial_if.sv
module tb_lcd3w_serial_if;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, wr = 1'b1, rd = 1'b1, din = 1'b0;
  logic dat_o, dat_oe, cmd_stb, bias_wr, bias_third, tb_wr;
  logic [8:0] cmd_code;
  logic [1:0] com_sel;
  logic [2:0] tb_sel;
  logic sys_dis, sys_en, lcd_off, lcd_on, irq_dis, irq_en;
  int checks = 0, fails = 0;
  int sc [9];
  bit done = 1'b0;

  always #2 clk = ~clk;

  lcd3w_serial_if dut (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .wr_clk_i(wr), .rd_clk_i(rd), .dat_i(din),
    .dat_o(dat_o), .dat_oe_o(dat_oe), .cmd_stb_o(cmd_stb), .cmd_code_o(cmd_code),
    .sys_dis_o(sys_dis), .sys_en_o(sys_en), .lcd_off_o(lcd_off), .lcd_on_o(lcd_on),
    .bias_wr_o(bias_wr), .com_sel_o(com_sel), .bias_third_o(bias_third),
    .irq_dis_o(irq_dis), .irq_en_o(irq_en), .tbase_wr_o(tb_wr), .tbase_sel_o(tb_sel)
  );

  always @(posedge clk) begin
    if (sys_dis) sc[0]++;
    if (sys_en)  sc[1]++;
    if (lcd_off) sc[2]++;
    if (lcd_on)  sc[3]++;
    if (bias_wr) sc[4]++;
    if (irq_dis) sc[5]++;
    if (irq_en)  sc[6]++;
    if (tb_wr)   sc[7]++;
    if (cmd_stb) sc[8]++;
  end

  // {kind[3:0], code[8:0]}; kind 8 = generic strobe only
  localparam logic [12:0] CMDV [0:9] = '{
    {4'd1, 9'b0000_0001_0}, {4'd3, 9'b0000_0011_1}, {4'd4, 9'b0010_1001_0},
    {4'd6, 9'b1000_1000_0}, {4'd5, 9'b1001_0111_1}, {4'd7, 9'b1010_0101_0},
    {4'd0, 9'b0000_0000_1}, {4'd2, 9'b0000_0010_0}, {4'd8, 9'b0110_0000_0},
    {4'd4, 9'b0010_0001_1}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_open;  wait_clk(1); cs_n = 1'b0; wait_clk(4); endtask
  task automatic cs_close; wait_clk(1); cs_n = 1'b1; wait_clk(4); endtask

  task automatic wbit(input logic b);
    din = b; wait_clk(1); wr = 1'b0; wait_clk(4); wr = 1'b1; wait_clk(4);
  endtask

  task automatic rbit(output logic b, output logic oe);
    wait_clk(1); rd = 1'b0; wait_clk(5); rd = 1'b1; wait_clk(1);
    b = dat_o; oe = dat_oe; wait_clk(3);
  endtask

  task automatic send_id(input logic [2:0] id);
    for (int i = 2; i >= 0; i--) wbit(id[i]);
  endtask

  task automatic send_addr(input logic [5:0] a);
    for (int i = 5; i >= 0; i--) wbit(a[i]);
  endtask

  task automatic send_nib(input logic [3:0] v);
    for (int i = 0; i < 4; i++) wbit(v[i]);
  endtask

  task automatic get_nib(output logic [3:0] v, output logic oe_all);
    logic b, oe;
    oe_all = 1'b1;
    for (int i = 0; i < 4; i++) begin rbit(b, oe); v[i] = b; oe_all &= oe; end
  endtask

  task automatic read_one(input logic [5:0] a, output logic [3:0] v);
    logic oe;
    cs_open; send_id(3'b110); send_addr(a); get_nib(v, oe); cs_close;
  endtask

  task automatic send_cmd(input logic [8:0] c);
    for (int i = 8; i >= 0; i--) wbit(c[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [3:0] v;
    logic oe, b;
    int base [9];
    for (int i = 0; i < 9; i++) sc[i] = 0;
    wait_clk(3); rst_n = 1'b1; wait_clk(3);

    // R1 reset state
    chk(dat_oe == 1'b0, "R1 oe after reset", dat_oe, 0);
    chk(sc[8] == 0 && cmd_stb == 1'b0, "R1 no strobe after reset", sc[8], 0);
    read_one(6'd5, v);
    chk(v == 4'h0, "R1 memory zero", v, 0);

    // R2/R3 single write and read
    cs_open; send_id(3'b101); send_addr(6'd10); send_nib(4'hA); cs_close;
    cs_open; send_id(3'b110); send_addr(6'd10); get_nib(v, oe);
    chk(v == 4'hA, "R2 R3 readback addr10", v, 4'hA);
    chk(oe == 1'b1, "R3 oe high while reading", oe, 1);
    // R11 immediate drop with select
    cs_n = 1'b1; #1;
    chk(dat_oe == 1'b0, "R11 oe drops with cs", dat_oe, 0);
    wait_clk(4);

    // R4 write burst wrapping 62,63,0
    cs_open; send_id(3'b101); send_addr(6'd62);
    chk(dat_oe == 1'b0, "R11 oe low in write phase", dat_oe, 0);
    send_nib(4'h1); send_nib(4'h2); send_nib(4'h3); cs_close;
    cs_open; send_id(3'b110); send_addr(6'd62);
    get_nib(v, oe); chk(v == 4'h1, "R4 burst nibble 62", v, 1);
    get_nib(v, oe); chk(v == 4'h2, "R4 burst nibble 63", v, 2);
    get_nib(v, oe); chk(v == 4'h3, "R4 burst wrap to 0", v, 3);
    cs_close;

    // R5 read-modify-write over two addresses
    cs_open; send_id(3'b101); send_addr(6'd20); send_nib(4'h6); send_nib(4'hC); cs_close;
    cs_open; send_id(3'b101); send_addr(6'd20);
    get_nib(v, oe); chk(v == 4'h6, "R5 rmw reads addr20", v, 6);
    chk(oe == 1'b1, "R5 oe during rmw read", oe, 1);
    send_nib(4'h9);
    chk(dat_oe == 1'b0, "R11 oe low after rmw write", dat_oe, 0);
    get_nib(v, oe); chk(v == 4'hC, "R5 rmw reads addr21", v, 4'hC);
    send_nib(4'h3); cs_close;
    read_one(6'd20, v); chk(v == 4'h9, "R5 addr20 replaced", v, 9);
    read_one(6'd21, v); chk(v == 4'h3, "R5 addr21 replaced", v, 3);

    // R6 R7 R8 chained command table
    cs_open; send_id(3'b100);
    for (int k = 0; k < 10; k++) begin
      int kind;
      logic [8:0] c;
      for (int j = 0; j < 9; j++) base[j] = sc[j];
      kind = int'(CMDV[k][12:9]);
      c = CMDV[k][8:0];
      send_cmd(c);
      chk(sc[8] == base[8] + 1, "R6 one cmd strobe", sc[8] - base[8], 1);
      chk(cmd_code == c, "R6 cmd code", cmd_code, c);
      for (int j = 0; j < 8; j++)
        chk(sc[j] == base[j] + ((j == kind) ? 1 : 0), "R7 decoded strobe", sc[j] - base[j], (j == kind) ? 1 : 0);
      if (kind == 4) begin
        chk(com_sel == c[4:3], "R8 commons field", com_sel, c[4:3]);
        chk(bias_third == c[1], "R8 bias field", bias_third, c[1]);
      end
      if (kind == 7) chk(tb_sel == c[3:1], "R8 time-base field", tb_sel, c[3:1]);
    end
    cs_close;

    // R9 abort mid-nibble
    cs_open; send_id(3'b101); send_addr(6'd30); wbit(1'b1); wbit(1'b1); cs_close;
    read_one(6'd30, v);
    chk(v == 4'h0, "R9 partial nibble dropped", v, 0);
    // R9 bare command without mode code is not accepted
    base[8] = sc[8]; base[3] = sc[3];
    cs_open; send_cmd(9'b0000_0011_0); cs_close;
    chk(sc[8] == base[8] && sc[3] == base[3], "R9 no strobe without mode code", sc[8] - base[8], 0);

    // R10 unknown mode code 111 is inert
    base[8] = sc[8];
    cs_open; send_id(3'b111); send_addr(6'd10); send_nib(4'h5);
    rbit(b, oe);
    chk(oe == 1'b0, "R10 oe low after bad code", oe, 0);
    cs_close;
    chk(sc[8] == base[8], "R10 no strobe after bad code", sc[8] - base[8], 0);
    read_one(6'd10, v);
    chk(v == 4'hA, "R10 memory unchanged", v, 4'hA);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule